// File: doc/BRIEF.md
# Late-Write Byte-Lane Synchronous SRAM

This block is a single-clock static RAM that follows a late-write protocol. On each rising edge it registers a command made of an address, an active-low select, an active-low write strobe and one active-low write enable per 9-bit lane. A write's data word does not come with its command. It is sampled one edge later. A read's word is launched from the edge after the command and holds for one cycle. The data bus is modelled as three signals: an input word, an output word and a drive enable. When the drive enable is low, the bus is in high impedance. An asynchronous active-low output gate and a sleep input can take the drivers off the bus.

Inside, a three-state command register holds the command captured at the last edge: `OP_IDLE`, `OP_READ` or `OP_WRITE`. Transitions happen on every edge. Sleep, a deselect, or a write with no lane enabled leads to `OP_IDLE`. A selected read leads to `OP_READ`. A selected write with at least one lane enabled leads to `OP_WRITE`.

At the edge after the command, `OP_READ` loads the output register and `OP_WRITE` loads a one-entry write buffer. Each of these edges makes exactly one array access. A write is committed from the buffer to the array on the edge where the next write's data arrives. A read that hits the buffered address takes the buffered lanes merged with the array word.

Top module: `lws_sram`

## Requirements
- R1: A write registered at edge E (select low, write strobe low, at least one lane enable low) stores the input word sampled at edge E+1 at the address sampled at edge E.
- R2: A read registered at edge E (select low, write strobe high) drives the full word stored at that address from edge E+1 until edge E+2, with the drive enable high, provided the output gate is low.
- R3: Lane i covers data bits 9*i to 9*i+8. A write changes lane i only when lane enable bit i was low at the command edge. Other lanes keep their contents.
- R4: A write with every lane enable high is aborted. No location changes, and the drive enable stays low in the cycles that follow.
- R5: When select is high at an edge, that edge is a deselect whatever the write strobe is. No location changes, and no read data is launched for it.
- R6: Lane enables have no effect on reads. The full word is returned.
- R7: While sleep is high, the drive enable is low at once. An edge with sleep high ignores every other input, including the data word owed to a preceding write. The bus stays undriven in the cycle after that edge.
- R8: The output gate is asynchronous. While it is high, the drive enable is low without waiting for an edge. When it goes low inside a read's output cycle, the word appears at once.
- R9: While reset is asserted, and after it, the drive enable is low until a read launches data.
- R10: A read of an address whose write is still held in the buffer returns the newly written lanes merged with the older contents of the other lanes.
- R11: If a write is registered at the edge that would launch a preceding read's data, the block does not drive in that cycle, because the host supplies write data then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands and write data are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select, registered |
| wr_n | input | 1 | Active-low write strobe, registered |
| lane_wr_n | input | LANES | Active-low per-lane write enables, registered |
| addr | input | clog2(DEPTH) | Word address, registered |
| sleep | input | 1 | Active-high sleep; ignores all other inputs |
| oe_n | input | 1 | Asynchronous active-low output gate |
| dq_i | input | LANES*LANE_W | Bus input word, sampled one edge after a write command |
| dq_o | output | LANES*LANE_W | Bus output word |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
The bench builds the block with 16 words of four 9-bit lanes. Because the address space is small, random traffic often reads an address while its write is still in the buffer. It also often issues back-to-back read and write pairs to one address, so the forwarding merge and the read-then-write drive suppression occur many times. Directed sequences cover partial-lane writes, aborted writes, deselects that carry a low write strobe, sleep edges that swallow owed write data, and the output gate dropping in the middle of a read cycle.

// File: rtl/lws_pkg.sv
package lws_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl #(
    parameter int LANES = 4,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    addr,
    input  logic             sleep,
    output logic [AW-1:0]    addr_q,
    output logic [LANES-1:0] mask_q,
    output logic             drive_q,
    output logic             do_read,
    output logic             do_write
);
    import lws_pkg::*;

    op_e  op_q, op_d;
    logic drive_d;

    // next command from the inputs at this edge
    always_comb begin
        if (sleep)            op_d = OP_IDLE;
        else if (sel_n)       op_d = OP_IDLE;
        else if (wr_n)        op_d = OP_READ;
        else if (&lane_wr_n)  op_d = OP_IDLE;
        else                  op_d = OP_WRITE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            drive_q <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            op_q    <= op_d;
            drive_q <= drive_d;
            if (op_d != OP_IDLE) begin
                addr_q <= addr;
                mask_q <= ~lane_wr_n;
            end
        end
    end

    // actions of the registered command at the coming edge
    always_comb begin
        do_read  = 1'b0;
        do_write = 1'b0;
        unique case (op_q)
            OP_IDLE:  ;
            OP_READ:  do_read  = !sleep;
            OP_WRITE: do_write = !sleep;
            default:  ;
        endcase
        drive_d = do_read && (op_d != OP_WRITE);
    end

    assert_launch_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> $past(op_q == OP_READ));

    assert_no_drive_in_wdata_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> !drive_q);

    assert_deselect_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_n) |-> (op_q == OP_IDLE));

    assert_sleep_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> (op_q == OP_IDLE && !drive_q));
endmodule

// File: rtl/lws_stage.sv
module lws_stage #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int AW     = 6,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_write,
    input  logic [AW-1:0]    addr_q,
    input  logic [LANES-1:0] mask_q,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    rd_addr,
    input  logic [W-1:0]     arr_rdata,
    output logic             cmt_en,
    output logic [AW-1:0]    cmt_addr,
    output logic [LANES-1:0] cmt_mask,
    output logic [W-1:0]     cmt_data,
    output logic [W-1:0]     fwd_rdata
);
    logic             pend_v;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic [W-1:0]     pend_data;
    logic             hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
            pend_data <= '0;
        end else if (do_write) begin
            pend_v    <= 1'b1;
            pend_addr <= addr_q;
            pend_mask <= mask_q;
            pend_data <= wdata;
        end
    end

    // older entry drains to the array when a newer write lands
    assign cmt_en   = do_write && pend_v;
    assign cmt_addr = pend_addr;
    assign cmt_mask = pend_mask;
    assign cmt_data = pend_data;

    assign hit = pend_v && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign fwd_rdata[g*LANE_W +: LANE_W] = (hit && pend_mask[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_rdata[g*LANE_W +: LANE_W];
    end

    assert_buffer_has_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |-> (pend_mask != '0));
endmodule

// File: rtl/lws_array.sv
module lws_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wmask,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lws_sram.sv
module lws_sram #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    addr,
    input  logic             sleep,
    input  logic             oe_n,
    input  logic [W-1:0]     dq_i,
    output logic [W-1:0]     dq_o,
    output logic             dq_oe
);
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] mask_q;
    logic             drive_q, do_read, do_write;
    logic             cmt_en;
    logic [AW-1:0]    cmt_addr;
    logic [LANES-1:0] cmt_mask;
    logic [W-1:0]     cmt_data, arr_rdata, fwd_rdata, dout_q;

    lws_ctrl #(.LANES(LANES), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .sleep(sleep),
        .addr_q(addr_q), .mask_q(mask_q), .drive_q(drive_q),
        .do_read(do_read), .do_write(do_write)
    );

    lws_stage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_stage (
        .clk(clk), .rst_n(rst_n), .do_write(do_write),
        .addr_q(addr_q), .mask_q(mask_q), .wdata(dq_i),
        .rd_addr(addr_q), .arr_rdata(arr_rdata),
        .cmt_en(cmt_en), .cmt_addr(cmt_addr), .cmt_mask(cmt_mask),
        .cmt_data(cmt_data), .fwd_rdata(fwd_rdata)
    );

    lws_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .we(cmt_en), .waddr(cmt_addr), .wmask(cmt_mask),
        .wdata(cmt_data), .raddr(addr_q), .rdata(arr_rdata)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout_q <= '0;
        else if (do_read) dout_q <= fwd_rdata;
    end

    assign dq_o  = dout_q;
    assign dq_oe = drive_q && !oe_n && !sleep;

    assert_word_held_while_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !do_read) |=> $stable(dq_o));
endmodule

// File: tb/sim_lws_sram.sv
module sim_lws_sram;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int W      = LANES * LANE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, wr_n = 1'b1, sleep = 1'b0, oe_n = 1'b0;
    logic [LANES-1:0] lane_wr_n = '1;
    logic [3:0] addr = '0;
    logic [W-1:0] dq_i = '0;
    logic [W-1:0] dq_o;
    logic dq_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [W-1:0] model [DEPTH];
    bit prev_wr = 0, prev_rd = 0;
    logic [3:0] prev_addr = '0;
    logic [LANES-1:0] prev_mask = '0;
    logic exp_drive = 1'b0;
    logic [W-1:0] exp_data = '0;

    lws_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .sleep(sleep), .oe_n(oe_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int classify(input logic s_n, input logic w_n, input logic [LANES-1:0] ln, input logic slp);
        if (slp || s_n) return 0;
        if (w_n) return 1;
        if (&ln) return 0;
        return 2;
    endfunction

    task automatic check_bus(input logic oen, input logic slp, input string tag);
        logic exp_oe;
        exp_oe = exp_drive && !oen && !slp;
        chk(dq_oe === exp_oe, tag, {{(W-1){1'b0}}, dq_oe}, {{(W-1){1'b0}}, exp_oe});
        if (exp_oe) chk(dq_o === exp_data, tag, dq_o, exp_data);
    endtask

    // one edge: set inputs after a falling edge, model the rising edge, check at the next falling edge
    task automatic step(input logic s_n, input logic w_n, input logic [LANES-1:0] ln,
                        input logic [3:0] a, input logic slp, input logic oen, input string tag);
        logic [63:0] r;
        logic [W-1:0] wd;
        int cls;
        r = {$urandom(), $urandom()};
        wd = r[W-1:0];
        sel_n = s_n; wr_n = w_n; lane_wr_n = ln; addr = a; sleep = slp; oe_n = oen; dq_i = wd;
        #1;
        check_bus(oen, slp, oen ? "R8 async" : (slp ? "R7 async" : tag));
        cls = classify(s_n, w_n, ln, slp);
        @(posedge clk);
        if (slp) begin
            exp_drive = 1'b0;
        end else begin
            if (prev_wr)
                for (int i = 0; i < LANES; i++)
                    if (prev_mask[i]) model[prev_addr][i*LANE_W +: LANE_W] = wd[i*LANE_W +: LANE_W];
            if (prev_rd) begin
                exp_data  = model[prev_addr];
                exp_drive = (cls != 2);
            end else begin
                exp_drive = 1'b0;
            end
        end
        prev_wr = (cls == 2);
        prev_rd = (cls == 1);
        if (cls != 0) begin
            prev_addr = a;
            prev_mask = ~ln;
        end
        @(negedge clk);
        check_bus(oen, slp, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b1, '1, 4'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, 1'b1, 4'($urandom()), a, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [LANES-1:0] ln, input string tag);
        step(1'b0, 1'b0, ln, a, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1a7e));
        repeat (3) @(negedge clk);
        chk(dq_oe === 1'b0, "R9 in reset", {{(W-1){1'b0}}, dq_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe === 1'b0, "R9 after reset", {{(W-1){1'b0}}, dq_oe}, '0);

        // R1: fill every word with full-lane writes back to back
        for (int a = 0; a < DEPTH; a++) wr(4'(a), 4'h0, "R1 fill");
        idle("R1 fill");
        for (int a = 0; a < DEPTH; a++) rd(4'(a), "R1 readback");
        idle("R1 readback");

        // R2: single read, then idle cycles
        rd(4'd3, "R2"); idle("R2"); idle("R2");

        // R10: read straight after a write to the same word, full and partial
        wr(4'd5, 4'h0, "R10"); rd(4'd5, "R10"); idle("R10");
        wr(4'd5, 4'b1101, "R10"); rd(4'd5, "R10"); idle("R10");
        wr(4'd6, 4'b0000, "R10"); rd(4'd5, "R10"); rd(4'd6, "R10"); idle("R10");

        // R3: lanes 0 and 3 written, lanes 1 and 2 kept
        wr(4'd7, 4'b0110, "R3"); idle("R3"); rd(4'd7, "R3"); idle("R3");
        wr(4'd7, 4'b1011, "R3"); wr(4'd8, 4'b1110, "R3"); rd(4'd7, "R3"); rd(4'd8, "R3"); idle("R3");

        // R4: aborted write leaves the word and the bus alone
        wr(4'd8, 4'hF, "R4"); idle("R4"); rd(4'd8, "R4"); idle("R4");

        // R5: deselect with the write strobe low changes nothing
        step(1'b1, 1'b0, 4'h0, 4'd9, 1'b0, 1'b0, "R5");
        idle("R5"); rd(4'd9, "R5"); idle("R5");

        // R6: reads with every lane-enable pattern return the full word
        step(1'b0, 1'b1, 4'h0, 4'd10, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 4'hA, 4'd10, 1'b0, 1'b0, "R6");
        idle("R6");

        // R11: write registered where the read would launch
        rd(4'd11, "R11"); wr(4'd12, 4'h0, "R11"); idle("R11");
        rd(4'd12, "R11"); idle("R11");

        // R7: sleep mid read, sleep swallowing write data, read command during sleep
        rd(4'd2, "R7"); idle("R7");
        step(1'b1, 1'b1, '1, 4'd0, 1'b1, 1'b0, "R7");
        idle("R7");
        wr(4'd13, 4'h0, "R7");
        step(1'b1, 1'b1, '1, 4'd0, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 4'h0, 4'd13, 1'b1, 1'b0, "R7");
        idle("R7");
        rd(4'd13, "R7"); idle("R7");

        // R8: output gate high during a read cycle, then released within the next one
        rd(4'd4, "R8");
        step(1'b0, 1'b1, 4'h0, 4'd4, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b1, 4'h0, 4'd4, 1'b0, 1'b0, "R8");
        idle("R8");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            step(($urandom() % 8) == 0, ($urandom() % 2) == 1,
                 (($urandom() % 5) == 0) ? 4'hF : 4'($urandom()),
                 4'($urandom()), ($urandom() % 32) == 0, ($urandom() % 16) == 0, "R2 random");
        end
        idle("R2 drain");
        idle("R2 drain");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule